// File: doc/BRIEF.md
# SDRAM Bank Timing Checker

This block watches the decoded command stream that a memory controller sends to a four-bank DDR2-style SDRAM and reports every command that breaks the rules for bank state or for row-activation timing. It keeps the state of each bank separately. For each bank it holds whether a row is open, the number of that row, and down-counters for the time that remains before a column access, a precharge or a new activate becomes legal.

A command that is flagged is reported one cycle after it is seen, together with a reason code and the bank it addressed. A flagged command does not change the state the checker keeps. Read and write commands can ask for auto precharge. The checker then closes the bank and times the row-precharge interval from the moment the device precharges internally, which is a fixed number of cycles after the column command. All intervals are parameters counted in clock cycles.

Top module: `sdram_bank_checker`

## Requirements
- R1: After a synchronous reset all banks are closed, `viol_o` is low, and an activate to any bank in the first cycle after reset is accepted without a flag.
- R2: Command codes on `cmd_i` are 0 idle, 1 activate, 2 read, 3 write and 4 precharge, and any other value is idle. A flagged command at clock edge k sets `viol_o` high for the cycle after edge k. In that cycle `viol_bank_o` holds the bank and `reason_o` holds the code: 0 none, 1 bank not open, 2 bank already open, 3 tRCD short, 4 tRAS short, 5 tRP short, 6 tRC short. At all other times `viol_o` is low.
- R3: A read or write to a closed bank is flagged with code 1.
- R4: An activate to a bank that already has an open row is flagged with code 2. An accepted activate opens the bank with the row on `row_i`.
- R5: A read or write issued fewer than TRCD_CYC cycles after the accepted activate of its bank is flagged with code 3.
- R6: A precharge to an open bank issued fewer than TRAS_CYC cycles after its activate is flagged with code 4. A precharge to a closed bank is not flagged and changes no state.
- R7: An activate issued fewer than TRP_CYC cycles after the precharge that closed its bank is flagged with code 5.
- R8: An activate issued fewer than TRC_CYC cycles after the previous accepted activate of its bank is flagged with code 6.
- R9: An accepted read or write with `ap_i` high closes the bank. Its precharge counts as taking place AP_LAT_CYC cycles later, and tRP is timed from that point.
- R10: A flagged command leaves the open flag, the stored row and all counters of every bank unchanged.
- R11: Banks are independent: commands to one bank never cause a flag or a state change in another bank.
- R12: When several rules fail at once, the reported code is the first that applies in this order: 1 or 2 (open state), then 5 before 6 for activates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_i | input | 3 | Decoded command code |
| bank_i | input | 2 | Bank addressed by the command |
| row_i | input | 13 | Row address used with activate |
| ap_i | input | 1 | Auto-precharge request with read or write |
| viol_o | output | 1 | One-cycle violation pulse |
| reason_o | output | 3 | Reason code of the reported violation |
| viol_bank_o | output | 2 | Bank of the reported violation |
| open_mask_o | output | 4 | Open flag of each bank, bit n for bank n |
| open_rows_o | output | 52 | Stored row of each bank, bank n in bits 13n+12..13n |

## Verification
The bench builds the checker with short intervals: TRCD 2, TRAS 4, TRP 2, TRC 7 and auto-precharge latency 2. With TRC larger than TRAS plus TRP, a tRC violation can be produced on its own after a legal precharge. These small values let the bench sweep every gap from zero up to one past each limit, on all four banks. The bench compares each result against issue-cycle arithmetic, so both edges of every window, the auto-precharge offset and the priority between codes are each checked.

// File: rtl/sdrt_pkg.sv
package sdrt_pkg;
    typedef enum logic [2:0] {
        CMD_IDLE  = 3'd0,
        CMD_ACT   = 3'd1,
        CMD_READ  = 3'd2,
        CMD_WRITE = 3'd3,
        CMD_PRE   = 3'd4
    } cmd_t;

    typedef enum logic [2:0] {
        RSN_NONE     = 3'd0,
        RSN_NOT_OPEN = 3'd1,
        RSN_IS_OPEN  = 3'd2,
        RSN_RCD      = 3'd3,
        RSN_RAS      = 3'd4,
        RSN_RP       = 3'd5,
        RSN_RC       = 3'd6
    } reason_t;
endpackage

// File: rtl/sdrt_bank_track.sv
module sdrt_bank_track
    import sdrt_pkg::*;
#(
    parameter int ROW_W      = 13,
    parameter int TRCD_CYC   = 6,
    parameter int TRAS_CYC   = 18,
    parameter int TRP_CYC    = 6,
    parameter int TRC_CYC    = 24,
    parameter int AP_LAT_CYC = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_i,
    input  logic [2:0]       cmd_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic             ap_i,
    output reason_t          reason_o,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o
);
    localparam int AP_RP = TRP_CYC + AP_LAT_CYC;
    localparam int M1    = (TRC_CYC > TRAS_CYC) ? TRC_CYC : TRAS_CYC;
    localparam int M2    = (TRCD_CYC > AP_RP) ? TRCD_CYC : AP_RP;
    localparam int MAXC  = (M1 > M2) ? M1 : M2;
    localparam int CW    = $clog2(MAXC + 1);

    typedef struct packed {
        logic             open;
        logic [ROW_W-1:0] row;
        logic [CW-1:0]    rcd;
        logic [CW-1:0]    ras;
        logic [CW-1:0]    rc;
        logic [CW-1:0]    rp;
    } bank_st_t;

    bank_st_t st_d, st_q;
    reason_t  reason_d;

    always_comb begin
        st_d     = st_q;
        reason_d = RSN_NONE;
        if (st_q.rcd != '0) st_d.rcd = st_q.rcd - 1'b1;
        if (st_q.ras != '0) st_d.ras = st_q.ras - 1'b1;
        if (st_q.rc  != '0) st_d.rc  = st_q.rc  - 1'b1;
        if (st_q.rp  != '0) st_d.rp  = st_q.rp  - 1'b1;
        if (sel_i) begin
            case (cmd_i)
                CMD_ACT: begin
                    if (st_q.open)           reason_d = RSN_IS_OPEN;
                    else if (st_q.rp != '0)  reason_d = RSN_RP;
                    else if (st_q.rc != '0)  reason_d = RSN_RC;
                    else begin
                        st_d.open = 1'b1;
                        st_d.row  = row_i;
                        st_d.rcd  = CW'(TRCD_CYC - 1);
                        st_d.ras  = CW'(TRAS_CYC - 1);
                        st_d.rc   = CW'(TRC_CYC - 1);
                    end
                end
                CMD_READ, CMD_WRITE: begin
                    if (!st_q.open)          reason_d = RSN_NOT_OPEN;
                    else if (st_q.rcd != '0) reason_d = RSN_RCD;
                    else if (ap_i) begin
                        st_d.open = 1'b0;
                        st_d.rp   = CW'(AP_RP - 1);
                    end
                end
                CMD_PRE: begin
                    if (st_q.open) begin
                        if (st_q.ras != '0) reason_d = RSN_RAS;
                        else begin
                            st_d.open = 1'b0;
                            st_d.rp   = CW'(TRP_CYC - 1);
                        end
                    end
                end
                default: ;
            endcase
        end
        if (reason_d != RSN_NONE) st_d = st_q;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign reason_o = reason_d;
    assign open_o   = st_q.open;
    assign row_o    = st_q.row;

    assert_act_opens_R4: assert property (@(posedge clk) disable iff (rst)
        (sel_i && cmd_i == CMD_ACT && reason_o == RSN_NONE)
        |=> (open_o && row_o == $past(row_i)));

    assert_flag_keeps_state_R10: assert property (@(posedge clk) disable iff (rst)
        (reason_o != RSN_NONE) |=> ($stable(open_o) && $stable(row_o)));

    assert_pre_closes_R6: assert property (@(posedge clk) disable iff (rst)
        (sel_i && cmd_i == CMD_PRE && open_o && reason_o == RSN_NONE) |=> !open_o);

    assert_ap_closes_R9: assert property (@(posedge clk) disable iff (rst)
        (sel_i && (cmd_i == CMD_READ || cmd_i == CMD_WRITE) && ap_i && reason_o == RSN_NONE)
        |=> (!open_o && st_q.rp != '0));

    assert_idle_bank_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        (!sel_i) |-> (reason_o == RSN_NONE));
endmodule

// File: rtl/sdrt_report.sv
module sdrt_report
    import sdrt_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  reason_t           reason_i,
    input  logic [BANK_W-1:0] bank_i,
    output logic              viol_o,
    output reason_t           reason_o,
    output logic [BANK_W-1:0] bank_o
);
    typedef struct packed {
        logic              viol;
        reason_t           reason;
        logic [BANK_W-1:0] bank;
    } rep_t;

    rep_t rep_d, rep_q;

    always_comb begin
        rep_d        = '0;
        rep_d.reason = RSN_NONE;
        if (reason_i != RSN_NONE) begin
            rep_d.viol   = 1'b1;
            rep_d.reason = reason_i;
            rep_d.bank   = bank_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rep_q <= '0;
        else     rep_q <= rep_d;
    end

    assign viol_o   = rep_q.viol;
    assign reason_o = rep_q.reason;
    assign bank_o   = rep_q.bank;

    assert_pulse_follows_R2: assert property (@(posedge clk) disable iff (rst)
        (reason_i != RSN_NONE) |=> (viol_o && reason_o == $past(reason_i) && bank_o == $past(bank_i)));

    assert_quiet_when_clean_R2: assert property (@(posedge clk) disable iff (rst)
        (reason_i == RSN_NONE) |=> !viol_o);
endmodule

// File: rtl/sdram_bank_checker.sv
module sdram_bank_checker
    import sdrt_pkg::*;
#(
    parameter int NUM_BANKS  = 4,
    parameter int ROW_W      = 13,
    parameter int TRCD_CYC   = 6,
    parameter int TRAS_CYC   = 18,
    parameter int TRP_CYC    = 6,
    parameter int TRC_CYC    = 24,
    parameter int AP_LAT_CYC = 2,
    localparam int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [2:0]                 cmd_i,
    input  logic [BANK_W-1:0]          bank_i,
    input  logic [ROW_W-1:0]           row_i,
    input  logic                       ap_i,
    output logic                       viol_o,
    output logic [2:0]                 reason_o,
    output logic [BANK_W-1:0]          viol_bank_o,
    output logic [NUM_BANKS-1:0]       open_mask_o,
    output logic [NUM_BANKS*ROW_W-1:0] open_rows_o
);
    reason_t trk_reason [NUM_BANKS];
    reason_t sel_reason;
    reason_t rep_reason;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        sdrt_bank_track #(
            .ROW_W(ROW_W), .TRCD_CYC(TRCD_CYC), .TRAS_CYC(TRAS_CYC),
            .TRP_CYC(TRP_CYC), .TRC_CYC(TRC_CYC), .AP_LAT_CYC(AP_LAT_CYC)
        ) u_trk (
            .clk     (clk),
            .rst     (rst),
            .sel_i   (bank_i == BANK_W'(b)),
            .cmd_i   (cmd_i),
            .row_i   (row_i),
            .ap_i    (ap_i),
            .reason_o(trk_reason[b]),
            .open_o  (open_mask_o[b]),
            .row_o   (open_rows_o[b*ROW_W +: ROW_W])
        );
    end

    assign sel_reason = trk_reason[bank_i];

    sdrt_report #(.BANK_W(BANK_W)) u_rep (
        .clk     (clk),
        .rst     (rst),
        .reason_i(sel_reason),
        .bank_i  (bank_i),
        .viol_o  (viol_o),
        .reason_o(rep_reason),
        .bank_o  (viol_bank_o)
    );

    assign reason_o = rep_reason;

    assert_rw_needs_open_R3: assert property (@(posedge clk) disable iff (rst)
        ((cmd_i == CMD_READ || cmd_i == CMD_WRITE) && !open_mask_o[bank_i])
        |=> (viol_o && reason_o == RSN_NOT_OPEN));

    assert_act_needs_closed_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == CMD_ACT && open_mask_o[bank_i]) |=> (viol_o && reason_o == RSN_IS_OPEN));

    assert_mask_steps_one_R11: assert property (@(posedge clk) disable iff (rst)
        $countones(open_mask_o ^ $past(open_mask_o)) <= 1);
endmodule

// File: tb/sim_sdram_bank_checker.sv
module sim_sdram_bank_checker;
    localparam int NB = 4, RW = 13;
    localparam int TRCD = 2, TRAS = 4, TRP = 2, TRC = 7, APL = 2;
    localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3, PRE = 3'd4;

    logic clk = 1'b0, rst = 1'b1;
    logic [2:0] cmd_i = NOP;
    logic [1:0] bank_i = '0;
    logic [RW-1:0] row_i = '0;
    logic ap_i = 1'b0;
    logic viol_o;
    logic [2:0] reason_o;
    logic [1:0] viol_bank_o;
    logic [NB-1:0] open_mask_o;
    logic [NB*RW-1:0] open_rows_o;

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    int m_open [NB];
    int m_row  [NB];
    int m_act  [NB];
    int m_rdy  [NB];

    always #10 clk = ~clk;

    sdram_bank_checker #(
        .NUM_BANKS(NB), .ROW_W(RW), .TRCD_CYC(TRCD), .TRAS_CYC(TRAS),
        .TRP_CYC(TRP), .TRC_CYC(TRC), .AP_LAT_CYC(APL)
    ) u0 (
        .clk(clk), .rst(rst), .cmd_i(cmd_i), .bank_i(bank_i), .row_i(row_i), .ap_i(ap_i),
        .viol_o(viol_o), .reason_o(reason_o), .viol_bank_o(viol_bank_o),
        .open_mask_o(open_mask_o), .open_rows_o(open_rows_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    function automatic string tag_of(input int r);
        case (r)
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            5: return "R7";
            6: return "R8";
            default: return "R2";
        endcase
    endfunction

    // One command slot: model the expected result, drive, check after the edge.
    task automatic step(input logic [2:0] c, input int b, input int r, input logic ap);
        int exp = 0;
        logic [NB-1:0] mask;
        @(negedge clk);
        if (c == ACT) begin
            if (m_open[b] != 0)             exp = 2;   // R12: open state first
            else if (cyc < m_rdy[b])        exp = 5;   // R12: tRP before tRC
            else if (cyc - m_act[b] < TRC)  exp = 6;
        end else if (c == RD || c == WR) begin
            if (m_open[b] == 0)             exp = 1;
            else if (cyc - m_act[b] < TRCD) exp = 3;
        end else if (c == PRE) begin
            if (m_open[b] != 0 && cyc - m_act[b] < TRAS) exp = 4;
        end
        cmd_i = c; bank_i = 2'(b); row_i = RW'(r); ap_i = ap;
        @(posedge clk); #1;
        chk(viol_o == (exp != 0), tag_of(exp), int'(viol_o), int'(exp != 0));
        if (exp != 0) begin
            chk(int'(reason_o) == exp, tag_of(exp), int'(reason_o), exp);
            chk(int'(viol_bank_o) == b, "R2", int'(viol_bank_o), b);
        end else begin
            if (c == ACT) begin
                m_open[b] = 1; m_row[b] = r; m_act[b] = cyc;
            end else if ((c == RD || c == WR) && ap) begin
                m_open[b] = 0; m_rdy[b] = cyc + APL + TRP;   // R9
            end else if (c == PRE && m_open[b] != 0) begin
                m_open[b] = 0; m_rdy[b] = cyc + TRP;
            end
        end
        for (int k = 0; k < NB; k++) mask[k] = (m_open[k] != 0);
        // R10 and R11: state of every bank matches the model
        chk(open_mask_o == mask, "R10", int'(open_mask_o), int'(mask));
        for (int k = 0; k < NB; k++)
            if (m_open[k] != 0)
                chk(int'(open_rows_o[k*RW +: RW]) == m_row[k], "R11",
                    int'(open_rows_o[k*RW +: RW]), m_row[k]);
        cyc++;
    endtask

    task automatic pad(input int n);
        for (int i = 0; i < n; i++) step(NOP, 0, 0, 1'b0);
    endtask

    initial begin
        for (int k = 0; k < NB; k++) begin
            m_open[k] = 0; m_row[k] = 0; m_act[k] = -100; m_rdy[k] = -100;
        end
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1: reset state
        chk(viol_o == 1'b0, "R1", int'(viol_o), 0);
        chk(open_mask_o == '0, "R1", int'(open_mask_o), 0);
        step(ACT, 2, 5, 1'b0);    // R1: accepted at once
        step(ACT, 0, 9, 1'b0);    // R11: other bank unaffected
        pad(TRC);
        step(PRE, 2, 0, 1'b0);
        step(PRE, 0, 0, 1'b0);
        pad(TRC);
        for (int b = 0; b < NB; b++) begin
            step(RD, b, 0, 1'b0);   // R3
            step(WR, b, 0, 1'b0);   // R3
            step(PRE, b, 0, 1'b0);  // R6: precharge to closed bank is silent
            step(ACT, b, 100 + b, 1'b0);  // no tRP restart from it
            pad(TRC); step(PRE, b, 0, 1'b0); pad(TRC);
            // R5 sweep
            for (int g = 1; g <= TRCD + 1; g++) begin
                step(ACT, b, g * 37 + b, 1'b0);
                pad(g - 1);
                step((g % 2) ? RD : WR, b, 0, 1'b0);
                pad(TRC); step(PRE, b, 0, 1'b0); pad(TRC);
            end
            // R6 sweep
            for (int g = 1; g <= TRAS + 1; g++) begin
                step(ACT, b, g * 11, 1'b0);
                pad(g - 1);
                step(PRE, b, 0, 1'b0);
                pad(TRC); step(PRE, b, 0, 1'b0); pad(TRC);
            end
            // R7 and R8 sweep: second activate after a legal precharge
            for (int g = 1; g <= TRP + TRC; g++) begin
                step(ACT, b, 7, 1'b0);
                pad(TRAS - 1);
                step(PRE, b, 0, 1'b0);
                pad(g - 1);
                step(ACT, b, 8 + g, 1'b0);
                pad(TRC); step(PRE, b, 0, 1'b0); pad(TRC);
            end
            // R4, R10, R12: activate onto an open row, also inside tRC
            step(ACT, b, 21, 1'b0);
            step(ACT, b, 22, 1'b0);
            pad(TRC);
            step(ACT, b, 23, 1'b0);
            step(PRE, b, 0, 1'b0);
            pad(TRC);
            // R9 sweep: auto precharge timing
            for (int g = 1; g <= APL + TRP + 1; g++) begin
                step(ACT, b, 300 + g, 1'b0);
                pad(TRCD - 1);
                step((g % 2) ? WR : RD, b, 0, 1'b1);
                pad(g - 1);
                step(ACT, b, 400 + g, 1'b0);
                pad(TRC); step(PRE, b, 0, 1'b0); pad(TRC);
            end
            step(ACT, b, 55, 1'b0);
            pad(TRCD - 1);
            step(RD, b, 0, 1'b1);
            step(RD, b, 0, 1'b0);   // R9: bank already closed
            pad(TRC);
        end
        // R11: interleaved traffic over all banks
        for (int b = 0; b < NB; b++) step(ACT, b, 500 + b, 1'b0);
        for (int b = 0; b < NB; b++) step(RD, b, 0, 1'b0);
        for (int b = 0; b < NB; b++) step(WR, b, 0, b[0]);
        pad(TRC);
        for (int b = 0; b < NB; b++) step(PRE, b, 0, 1'b0);
        pad(2);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule